// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small set of token latches that two independent agents, the left side and the right side, use to claim and hand back shared resources. The latches are kept apart from any data memory. A side reaches a latch by raising its semaphore select while its memory enable stays low. The low bits of its address pick the latch. A write strobe carries a request (data bit 0 low) or a release (data bit 0 high). A read strobe loads that side's view of the token into a per-side output register.

Each latch presents opposite views to the two sides. The owner reads 0 and the other side reads 1. A free latch reads 1 on both sides. A request from the side that does not own the latch is remembered. When the owner releases, the token passes straight to the waiting side. When both sides request the same free latch in the same cycle, the left side gets it and the right side's request is kept as pending.

Top module: `sem_bank`

## Requirements
- R1: The latch is chosen by the low log2(NSEM) address bits (bits 2:0 when NSEM=8). The other address bits have no effect.
- R2: A strobe acts only when its side's semaphore select is 1 and its memory enable is 0. Otherwise the strobe changes no latch and no read register.
- R3: A write uses data bit 0 only. Value 0 means request and value 1 means release or cancel. The other data bits are ignored.
- R4: When a side owns a latch, that side reads 0 and the other side reads 1. A free latch reads 1 on both sides.
- R5: A write of 1 from a side that does not own the latch leaves ownership unchanged. A write of 0 from a side that does not own a held latch records a pending request and leaves ownership unchanged.
- R6: When the owner writes 1 and the other side has a pending request, ownership moves to the other side in the same update. With no pending request, the latch becomes free.
- R7: A read loads the token value onto every bit of that side's read data one cycle after the strobe. The value then holds until that side's next read, whatever the other side writes.
- R8: At no time do both sides hold the same latch.
- R9: After reset all latches are free and both read registers are all ones.
- R10: When both sides write 0 to the same free latch in the same cycle, the left side gains the token and the right side's request stays pending. Within one cycle the left write is applied before the right write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sem_sel | input | 1 | Left semaphore select, active high |
| l_mem_ce | input | 1 | Left memory enable; when high, semaphore access is blocked |
| l_wr | input | 1 | Left write strobe |
| l_rd | input | 1 | Left read strobe |
| l_addr | input | AW | Left address |
| l_wdata | input | DW | Left write data (bit 0 used) |
| l_rdata | output | DW | Left read register |
| r_sem_sel | input | 1 | Right semaphore select, active high |
| r_mem_ce | input | 1 | Right memory enable; when high, semaphore access is blocked |
| r_wr | input | 1 | Right write strobe |
| r_rd | input | 1 | Right read strobe |
| r_addr | input | AW | Right address |
| r_wdata | input | DW | Right write data (bit 0 used) |
| r_rdata | output | DW | Right read register |

## Verification
The bench builds the block with its defaults: eight latches, a 16-bit address and an 18-bit data word. With only eight latches, random traffic from both sides lands on the same latch often. That makes same-cycle ties, pending hand-overs and reads that coincide with the other side's write frequent rather than rare. The wide address and data words leave many unused high bits, so random values in them exercise the ignored-bit rules on almost every access.

// File: rtl/sem_pkg.sv
package sem_pkg;

    typedef enum logic [1:0] {
        TOK_FREE  = 2'd0,
        TOK_LEFT  = 2'd1,
        TOK_RIGHT = 2'd2
    } tok_owner_e;

    typedef struct packed {
        tok_owner_e owner;
        logic       wait_l;
        logic       wait_r;
    } tok_state_t;

    localparam tok_state_t TOK_RESET = '{owner: TOK_FREE, wait_l: 1'b0, wait_r: 1'b0};

    // Applies one side's write to a latch state; from_left selects the side.
    function automatic tok_state_t tok_apply(tok_state_t s, logic from_left, logic val);
        tok_state_t n;
        tok_owner_e me;
        tok_owner_e other;
        logic       other_waits;
        n           = s;
        me          = from_left ? TOK_LEFT : TOK_RIGHT;
        other       = from_left ? TOK_RIGHT : TOK_LEFT;
        other_waits = from_left ? s.wait_r : s.wait_l;
        if (!val) begin
            if (s.owner == TOK_FREE) begin
                n.owner = me;
            end else if (s.owner != me) begin
                if (from_left) n.wait_l = 1'b1;
                else           n.wait_r = 1'b1;
            end
        end else begin
            if (s.owner == me) begin
                if (other_waits) begin
                    n.owner = other;
                    if (from_left) n.wait_r = 1'b0;
                    else           n.wait_l = 1'b0;
                end else begin
                    n.owner = TOK_FREE;
                end
            end else begin
                if (from_left) n.wait_l = 1'b0;
                else           n.wait_r = 1'b0;
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
    parameter int NSEM = 8,
    parameter int AW   = 16,
    parameter int DW   = 18,
    localparam int IW  = $clog2(NSEM)
) (
    input  logic            sem_sel,
    input  logic            mem_ce,
    input  logic            wr,
    input  logic            rd,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    output logic [NSEM-1:0] wr_hit,
    output logic            rd_go,
    output logic [IW-1:0]   idx,
    output logic            wbit
);
    logic access;
    logic unused_hi;

    assign unused_hi = ^{addr[AW-1:IW], wdata[DW-1:1]};

    always_comb begin
        access = sem_sel && !mem_ce;
        idx    = addr[IW-1:0];
        wbit   = wdata[0];
        rd_go  = access && rd;
        wr_hit = '0;
        if (access && wr) wr_hit[idx] = 1'b1;
    end
endmodule

// File: rtl/sem_latch.sv
module sem_latch
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_hit,
    input  logic l_bit,
    input  logic r_hit,
    input  logic r_bit,
    output logic l_owns,
    output logic r_owns
);
    tok_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (l_hit) st_d = tok_apply(st_d, 1'b1, l_bit);
        if (r_hit) st_d = tok_apply(st_d, 1'b0, r_bit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TOK_RESET;
        else        st_q <= st_d;
    end

    assign l_owns = (st_q.owner == TOK_LEFT);
    assign r_owns = (st_q.owner == TOK_RIGHT);
endmodule

// File: rtl/sem_rd_reg.sv
module sem_rd_reg #(
    parameter int NSEM = 8,
    parameter int DW   = 18,
    localparam int IW  = $clog2(NSEM)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_go,
    input  logic [IW-1:0]   idx,
    input  logic [NSEM-1:0] mine,
    output logic [DW-1:0]   rdata
);
    logic [DW-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (rd_go) rdata_d = {DW{!mine[idx]}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '1;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
    parameter int NSEM = 8,
    parameter int AW   = 16,
    parameter int DW   = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l_sem_sel,
    input  logic          l_mem_ce,
    input  logic          l_wr,
    input  logic          l_rd,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wdata,
    output logic [DW-1:0] l_rdata,
    input  logic          r_sem_sel,
    input  logic          r_mem_ce,
    input  logic          r_wr,
    input  logic          r_rd,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_wdata,
    output logic [DW-1:0] r_rdata
);
    localparam int IW = $clog2(NSEM);

    logic [NSEM-1:0] l_hit, r_hit;
    logic [NSEM-1:0] own_l, own_r;
    logic            l_rd_go, r_rd_go;
    logic [IW-1:0]   l_idx, r_idx;
    logic            l_bit, r_bit;

    sem_port_dec #(.NSEM(NSEM), .AW(AW), .DW(DW)) u_dec_l (
        .sem_sel(l_sem_sel), .mem_ce(l_mem_ce), .wr(l_wr), .rd(l_rd),
        .addr(l_addr), .wdata(l_wdata), .wr_hit(l_hit), .rd_go(l_rd_go),
        .idx(l_idx), .wbit(l_bit)
    );

    sem_port_dec #(.NSEM(NSEM), .AW(AW), .DW(DW)) u_dec_r (
        .sem_sel(r_sem_sel), .mem_ce(r_mem_ce), .wr(r_wr), .rd(r_rd),
        .addr(r_addr), .wdata(r_wdata), .wr_hit(r_hit), .rd_go(r_rd_go),
        .idx(r_idx), .wbit(r_bit)
    );

    for (genvar g = 0; g < NSEM; g++) begin : g_tok
        sem_latch u_tok (
            .clk(clk), .rst_n(rst_n),
            .l_hit(l_hit[g]), .l_bit(l_bit),
            .r_hit(r_hit[g]), .r_bit(r_bit),
            .l_owns(own_l[g]), .r_owns(own_r[g])
        );
    end

    sem_rd_reg #(.NSEM(NSEM), .DW(DW)) u_rd_l (
        .clk(clk), .rst_n(rst_n), .rd_go(l_rd_go), .idx(l_idx),
        .mine(own_l), .rdata(l_rdata)
    );

    sem_rd_reg #(.NSEM(NSEM), .DW(DW)) u_rd_r (
        .clk(clk), .rst_n(rst_n), .rd_go(r_rd_go), .idx(r_idx),
        .mine(own_r), .rdata(r_rdata)
    );
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
    parameter int NSEM = 8,
    parameter int AW   = 16,
    parameter int DW   = 18
) (
    input logic            clk,
    input logic            rst_n,
    input logic            l_sem_sel,
    input logic            l_mem_ce,
    input logic            l_wr,
    input logic            l_rd,
    input logic [AW-1:0]   l_addr,
    input logic [DW-1:0]   l_wdata,
    input logic [DW-1:0]   l_rdata,
    input logic            r_sem_sel,
    input logic            r_mem_ce,
    input logic            r_wr,
    input logic            r_rd,
    input logic [AW-1:0]   r_addr,
    input logic [DW-1:0]   r_wdata,
    input logic [DW-1:0]   r_rdata,
    input logic [NSEM-1:0] own_l,
    input logic [NSEM-1:0] own_r
);
    localparam int IW = $clog2(NSEM);

    logic          l_go, r_go;
    logic [IW-1:0] li, ri;
    assign l_go = l_sem_sel && !l_mem_ce;
    assign r_go = r_sem_sel && !r_mem_ce;
    assign li   = l_addr[IW-1:0];
    assign ri   = r_addr[IW-1:0];

    p_reset_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (own_l == '0 && own_r == '0 && l_rdata == '1 && r_rdata == '1));

    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (l_go && l_rd && r_go && r_rd && li == ri) |=> (l_rdata[0] || r_rdata[0]));

    p_hold_l_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_go && l_rd) |=> $stable(l_rdata));

    p_hold_r_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_go && r_rd) |=> $stable(r_rdata));

    p_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rdata == '0 || l_rdata == '1) && (r_rdata == '0 || r_rdata == '1));

    p_nonowner_rel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_go && r_wr && r_wdata[0] && !own_r[ri] && !(l_go && l_wr))
        |=> (own_l == $past(own_l) && own_r == $past(own_r)));

    p_tie_left_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (l_go && l_wr && !l_wdata[0] && r_go && r_wr && !r_wdata[0] && li == ri
         && !own_l[li] && !own_r[li]) |=> own_l[$past(li)]);

    p_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_go && !r_go) |=> (own_l == $past(own_l) && own_r == $past(own_r)));
endmodule

bind sem_bank sem_bank_chk #(.NSEM(NSEM), .AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_sem_sel(l_sem_sel), .l_mem_ce(l_mem_ce), .l_wr(l_wr), .l_rd(l_rd),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sem_sel(r_sem_sel), .r_mem_ce(r_mem_ce), .r_wr(r_wr), .r_rd(r_rd),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
    .own_l(own_l), .own_r(own_r)
);

// File: tb/sem_bank_test.sv
module sem_bank_test;
    localparam int NSEM = 8;
    localparam int AW   = 16;
    localparam int DW   = 18;
    localparam logic [DW-1:0] ONES = '1;
    localparam logic [DW-1:0] ZERO = '0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_sem_sel, l_mem_ce, l_wr, l_rd;
    logic r_sem_sel, r_mem_ce, r_wr, r_rd;
    logic [AW-1:0] l_addr, r_addr;
    logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;

    always #10 clk = ~clk;

    sem_bank #(.NSEM(NSEM), .AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .l_sem_sel(l_sem_sel), .l_mem_ce(l_mem_ce), .l_wr(l_wr), .l_rd(l_rd),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sem_sel(r_sem_sel), .r_mem_ce(r_mem_ce), .r_wr(r_wr), .r_rd(r_rd),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // model: 0 free, 1 left, 2 right
    int own[NSEM];
    bit wl[NSEM];
    bit wr_[NSEM];
    logic [DW-1:0] exp_l, exp_r;

    function automatic void model_wr(int i, bit left, bit v);
        int me = left ? 1 : 2;
        int ot = left ? 2 : 1;
        if (!v) begin
            if (own[i] == 0) own[i] = me;
            else if (own[i] != me) begin
                if (left) wl[i] = 1'b1; else wr_[i] = 1'b1;
            end
        end else if (own[i] == me) begin
            if (left ? wr_[i] : wl[i]) begin
                own[i] = ot;
                if (left) wr_[i] = 1'b0; else wl[i] = 1'b0;
            end else own[i] = 0;
        end else begin
            if (left) wl[i] = 1'b0; else wr_[i] = 1'b0;
        end
    endfunction

    task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        l_sem_sel = 1'b0; l_mem_ce = 1'b0; l_wr = 1'b0; l_rd = 1'b0;
        r_sem_sel = 1'b0; r_mem_ce = 1'b0; r_wr = 1'b0; r_rd = 1'b0;
        l_addr = '0; r_addr = '0; l_wdata = '0; r_wdata = '0;
    endtask

    // One clock with the current inputs; compares both read registers with the model.
    task automatic cyc(input string tag);
        int  li = int'(l_addr[2:0]);
        int  ri = int'(r_addr[2:0]);
        bit  lg = l_sem_sel && !l_mem_ce;
        bit  rg = r_sem_sel && !r_mem_ce;
        if (lg && l_rd) exp_l = (own[li] == 1) ? ZERO : ONES;
        if (rg && r_rd) exp_r = (own[ri] == 2) ? ZERO : ONES;
        if (lg && l_wr) model_wr(li, 1'b1, l_wdata[0]);
        if (rg && r_wr) model_wr(ri, 1'b0, r_wdata[0]);
        @(posedge clk);
        @(negedge clk);
        check(l_rdata, exp_l, {tag, " left"});
        check(r_rdata, exp_r, {tag, " right"});
    endtask

    task automatic lw(input logic [AW-1:0] a, input logic [DW-1:0] d);
        l_sem_sel = 1'b1; l_wr = 1'b1; l_addr = a; l_wdata = d;
    endtask
    task automatic rw(input logic [AW-1:0] a, input logic [DW-1:0] d);
        r_sem_sel = 1'b1; r_wr = 1'b1; r_addr = a; r_wdata = d;
    endtask
    task automatic both_rd(input logic [AW-1:0] a, input string tag);
        idle();
        l_sem_sel = 1'b1; l_rd = 1'b1; l_addr = a;
        r_sem_sel = 1'b1; r_rd = 1'b1; r_addr = a;
        cyc(tag);
        idle();
    endtask

    initial begin
        idle();
        for (int i = 0; i < NSEM; i++) begin own[i] = 0; wl[i] = 0; wr_[i] = 0; end
        exp_l = ONES; exp_r = ONES;
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        check(l_rdata, ONES, "R9 reset left");
        check(r_rdata, ONES, "R9 reset right");
        for (int i = 0; i < NSEM; i++) both_rd(AW'(i), "R9 all free");

        // R3 R4: left requests latch 3 with upper data bits set
        idle(); lw(16'h0003, 18'h3fffe); cyc("R3 request");
        both_rd(16'h0003, "R4 views");
        check(l_rdata, ZERO, "R4 owner reads 0");
        check(r_rdata, ONES, "R4 other reads 1");

        // R5: right release on latch it does not own
        idle(); rw(16'h0003, 18'h00001); cyc("R5 nonowner release");
        both_rd(16'h0003, "R5 unchanged");
        check(l_rdata, ZERO, "R5 left still owns");

        // R5 R6: right pends, left releases, token moves
        idle(); rw(16'h0003, 18'h00000); cyc("R5 pending");
        both_rd(16'h0003, "R5 pending no change");
        check(r_rdata, ONES, "R5 right not owner yet");
        idle(); lw(16'h0003, 18'h00001); cyc("R6 release");
        both_rd(16'h0003, "R6 handover");
        check(r_rdata, ZERO, "R6 right owns");
        check(l_rdata, ONES, "R6 left reads 1");
        idle(); rw(16'h0003, 18'h00001); cyc("R6 free again");
        both_rd(16'h0003, "R6 free");
        check(l_rdata & r_rdata, ONES, "R6 free both 1");

        // R1: upper address bits ignored
        idle(); lw(16'hfff5, 18'h00000); cyc("R1 high addr");
        both_rd(16'h0005, "R1 index");
        check(l_rdata, ZERO, "R1 latch 5 taken");

        // R2: blocked when memory enable is high
        idle(); lw(16'h0006, 18'h00000); l_mem_ce = 1'b1; cyc("R2 blocked write");
        idle(); l_sem_sel = 1'b1; l_mem_ce = 1'b1; l_rd = 1'b1; l_addr = 16'h0005;
        cyc("R2 blocked read");
        check(l_rdata, ZERO, "R2 read reg untouched");
        both_rd(16'h0006, "R2 latch 6 free");
        check(l_rdata, ONES, "R2 latch 6 still free");

        // R10 R8: same-cycle tie on latch 2
        idle(); lw(16'h0002, 18'h00000); rw(16'h0002, 18'h00000); cyc("R10 tie");
        both_rd(16'h0002, "R10 winner");
        check(l_rdata, ZERO, "R10 left wins");
        check(r_rdata, ONES, "R8 only one owner");
        idle(); lw(16'h0002, 18'h00001); cyc("R10 release");
        both_rd(16'h0002, "R10 pending kept");
        check(r_rdata, ZERO, "R10 right got pending token");

        // R7: left read frozen while right releases
        idle(); l_sem_sel = 1'b1; l_rd = 1'b1; l_addr = 16'h0002;
        rw(16'h0002, 18'h00001); cyc("R7 read during write");
        check(l_rdata, ONES, "R7 pre-write value");
        idle(); lw(16'h0002, 18'h00000); cyc("R7 hold");
        idle(); cyc("R7 hold2");
        check(l_rdata, ONES, "R7 frozen until next read");

        // random traffic, R4 R5 R6 R7 R8 R10 against the model
        for (int k = 0; k < 4000; k++) begin
            idle();
            l_sem_sel = ($urandom % 8) != 0;
            l_mem_ce  = ($urandom % 5) == 0;
            l_wr      = $urandom % 2;
            l_rd      = $urandom % 2;
            l_addr    = AW'($urandom);
            l_wdata   = DW'($urandom);
            r_sem_sel = ($urandom % 8) != 0;
            r_mem_ce  = ($urandom % 5) == 0;
            r_wr      = $urandom % 2;
            r_rd      = $urandom % 2;
            r_addr    = AW'($urandom);
            r_wdata   = DW'($urandom);
            if ($urandom % 3 == 0) r_addr[2:0] = l_addr[2:0];
            cyc("random R4 R5 R6 R7 R10");
        end

        idle();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule